// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a 64-word, 36-bit first-in first-out buffer that joins two clock domains that run independently. Port A writes on its own clock and port B reads on its own clock. Each port has four control inputs: a chip select (active low), a direction select, an enable and a mailbox select. A transfer takes place only when all four match the right combination and the relevant flag allows it. The mailbox path itself is not part of this block. Asserting the mailbox select only suppresses the FIFO transfer.

The block drives four active-low status flags: full, almost-full, empty and almost-empty. Full and almost-full are computed in the port-A domain. Empty and almost-empty are computed in the port-B domain. Pointers cross between the domains as Gray code through two-stage synchronizers. The almost-flag distance X is captured from a two-bit select input on the rising edge of the reset input. X is 4, 8, 12 or 16.

Each port also gets an output-enable signal, which replaces a tri-state data pad. Read data is held in a register that updates only when a read is accepted.

Top module: `dual_clock_fifo`

## Requirements
- R1: A word is written on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mbox`=0 and `full_n`=1. Any other combination writes nothing, and while `a_en`=0 toggling `a_cs_n`/`a_wr` has no effect.
- R2: A word is read on a rising `clk_b` edge only when `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_mbox`=0 and `empty_n`=1. Any other combination reads nothing and leaves the read position unchanged.
- R3: The word read appears on `b_dout` after the accepted read edge, in write order, and holds until the next accepted read. This holds with both ports active at unrelated clock rates.
- R4: `a_oe` is 1 exactly when `a_cs_n`=0 and `a_wr`=0. `b_oe` is 1 exactly when `b_cs_n`=0 and `b_wr`=0.
- R5: While `rst_n` is low, `full_n`=0, `empty_n`=0, `aempty_n`=0 and `afull_n`=1, and both pointers are cleared.
- R6: After `rst_n` rises, `full_n` stays 0 after the first rising `clk_a` edge and is 1 after the second.
- R7: On the rising edge of `rst_n`, X is loaded from `fsel` as follows: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12, 2'b11 gives 16. X is held until the next reset.
- R8: Once the flags have settled, `aempty_n` is 0 when the stored word count is at most X, and 1 otherwise.
- R9: Once the flags have settled, `afull_n` is 0 when the number of free locations (64 minus the count) is at most X, and 1 otherwise.
- R10: `full_n` is 0 whenever 64 words are stored, and `empty_n` is 0 whenever none are. A write attempted while full and a read attempted while empty are both dropped, and the pointers are left intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, asynchronous; its rising edge captures X |
| fsel | input | 2 | Almost-flag distance select |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mbox | input | 1 | Port A mailbox select; 1 suppresses the FIFO write |
| a_din | input | 36 | Write data |
| a_oe | output | 1 | Port A data output enable |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mbox | input | 1 | Port B mailbox select; 1 suppresses the FIFO read |
| b_dout | output | 36 | Read data register |
| b_oe | output | 1 | Port B data output enable |
| full_n | output | 1 | Full flag, active low (clk_a domain) |
| afull_n | output | 1 | Almost-full flag, active low (clk_a domain) |
| empty_n | output | 1 | Empty flag, active low (clk_b domain) |
| aempty_n | output | 1 | Almost-empty flag, active low (clk_b domain) |

## Verification
The properties rely on a few assumptions about the inputs:
- Reset is held low over several edges of both clocks.
- `fsel` is steady when reset is released.
- The control inputs of each port are stable around that port's rising edge.

The stimulus keeps within these assumptions. It drives every control input at the falling edge of its own clock, keeps reset low for five edges of each clock, and changes `fsel` only while reset is held. A write or read is predicted only from a flag value sampled at the same falling edge. Flags change only on their own clock's rising edge, so the prediction always matches what the design sees.

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic [1:0]    fsel,
  input  logic          a_cs_n,
  input  logic          a_wr,
  input  logic          a_en,
  input  logic          a_mbox,
  input  logic [DW-1:0] a_din,
  output logic          a_oe,
  input  logic          b_cs_n,
  input  logic          b_wr,
  input  logic          b_en,
  input  logic          b_mbox,
  output logic [DW-1:0] b_dout,
  output logic          b_oe,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] offset;
  logic [1:0]    rsa, rsb;
  logic [PW-1:0] wbin, wgray, rgray_a1, rgray_a2, rbin_a, used_a;
  logic [PW-1:0] rbin, rgray, wgray_b1, wgray_b2, wbin_b, used_b;
  logic          wr_fire, rd_fire;

  assign a_oe = !a_cs_n && !a_wr;
  assign b_oe = !b_cs_n && !b_wr;

  // distance X captured as reset is released
  always_ff @(posedge rst_n)
    offset <= PW'({fsel, 2'b00}) + PW'(4);

  // ---------------- write domain ----------------
  assign wr_fire = !a_cs_n && a_wr && a_en && !a_mbox && full_n;
  assign rbin_a  = gray2bin(rgray_a2);
  assign used_a  = wbin - rbin_a;
  assign full_n  = rsa[1] && (used_a != PW'(DEPTH));
  assign afull_n = !rsa[1] || ((PW'(DEPTH) - used_a) > offset);

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      rsa      <= '0;
      wbin     <= '0;
      wgray    <= '0;
      rgray_a1 <= '0;
      rgray_a2 <= '0;
    end else begin
      rsa      <= {rsa[0], 1'b1};
      rgray_a1 <= rgray;
      rgray_a2 <= rgray_a1;
      if (wr_fire) begin
        wbin  <= wbin + 1'b1;
        wgray <= bin2gray(wbin + 1'b1);
      end
    end

  always_ff @(posedge clk_a)
    if (wr_fire) mem[wbin[AW-1:0]] <= a_din;

  // ---------------- read domain ----------------
  assign rd_fire  = !b_cs_n && !b_wr && b_en && !b_mbox && empty_n;
  assign wbin_b   = gray2bin(wgray_b2);
  assign used_b   = wbin_b - rbin;
  assign empty_n  = rsb[1] && (used_b != '0);
  assign aempty_n = rsb[1] && (used_b > offset);

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      rsb      <= '0;
      rbin     <= '0;
      rgray    <= '0;
      wgray_b1 <= '0;
      wgray_b2 <= '0;
      b_dout   <= '0;
    end else begin
      rsb      <= {rsb[0], 1'b1};
      wgray_b1 <= wgray;
      wgray_b2 <= wgray_b1;
      if (rd_fire) begin
        b_dout <= mem[rbin[AW-1:0]];
        rbin   <= rbin + 1'b1;
        rgray  <= bin2gray(rbin + 1'b1);
      end
    end
endmodule

module dual_clock_fifo_chk #(
  parameter int PW = 7,
  parameter int DW = 36
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          a_en,
  input logic          a_mbox,
  input logic          b_en,
  input logic          b_mbox,
  input logic          full_n,
  input logic          afull_n,
  input logic [1:0]    rsa,
  input logic [PW-1:0] offset,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] rbin_a,
  input logic [PW-1:0] wbin_b,
  input logic          rd_fire,
  input logic [DW-1:0] b_dout
);
  localparam logic [PW-1:0] CAP = PW'(1 << (PW - 1));

  assert_idle_write_R1: assert property (@(posedge clk_a) disable iff (!rst_n)
    (!a_en || a_mbox) |=> $stable(wbin));

  assert_idle_read_R2: assert property (@(posedge clk_b) disable iff (!rst_n)
    (!b_en || b_mbox) |=> $stable(rbin));

  assert_hold_dout_R3: assert property (@(posedge clk_b) disable iff (!rst_n)
    !rd_fire |=> $stable(b_dout));

  assert_offset_legal_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    (offset[1:0] == 2'b00) && (offset >= PW'(4)) && (offset <= PW'(16)));

  assert_full_implies_afull_R9: assert property (@(posedge clk_a) disable iff (!rst_n)
    (rsa[1] && !full_n) |-> !afull_n);

  assert_no_overflow_R10: assert property (@(posedge clk_a) disable iff (!rst_n)
    PW'(wbin - rbin_a) <= CAP);

  assert_no_underflow_R10: assert property (@(posedge clk_b) disable iff (!rst_n)
    PW'(wbin_b - rbin) <= CAP);
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.PW(AW + 1), .DW(DW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
  .a_en(a_en), .a_mbox(a_mbox), .b_en(b_en), .b_mbox(b_mbox),
  .full_n(full_n), .afull_n(afull_n), .rsa(rsa), .offset(offset),
  .wbin(wbin), .rbin(rbin), .rbin_a(rbin_a), .wbin_b(wbin_b),
  .rd_fire(rd_fire), .b_dout(b_dout)
);

// File: tb/dual_clock_fifo_tb.sv
`timescale 1ns/100ps
module dual_clock_fifo_tb;
  logic        clk_a = 0, clk_b = 0, rst_n = 0;
  logic [1:0]  fsel = 0;
  logic        a_cs_n = 1, a_wr = 1, a_en = 0, a_mbox = 0;
  logic [35:0] a_din = 0;
  logic        b_cs_n = 1, b_wr = 1, b_en = 0, b_mbox = 0;
  logic        a_oe, b_oe, full_n, afull_n, empty_n, aempty_n;
  logic [35:0] b_dout;

  int n_cmp = 0, n_bad = 0, cnt = 0, xoff = 4;
  bit mon_on = 0;
  logic [35:0] q[$];

  always #4 clk_a = ~clk_a;
  always #6.5 clk_b = ~clk_b;

  dual_clock_fifo u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .fsel(fsel),
    .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mbox(a_mbox), .a_din(a_din), .a_oe(a_oe),
    .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mbox(b_mbox), .b_dout(b_dout), .b_oe(b_oe),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // R10 checked on every clock while the bench model says full or empty
  always @(negedge clk_a)
    if (mon_on && cnt == 64) chk(full_n == 0, "R10", "full_n at 64 words", full_n, 0);
  always @(negedge clk_b)
    if (mon_on && cnt == 0) chk(empty_n == 0, "R10", "empty_n at 0 words", empty_n, 0);

  task automatic settle();
    repeat (4) @(posedge clk_a);
    repeat (4) @(posedge clk_b);
    @(negedge clk_b);
  endtask

  task automatic check_flags(input string ctx);
    chk(full_n == (cnt != 64), "R10", {ctx, " full_n"}, full_n, cnt != 64);
    chk(empty_n == (cnt != 0), "R10", {ctx, " empty_n"}, empty_n, cnt != 0);
    chk(afull_n == ((64 - cnt) > xoff), "R9", {ctx, " afull_n"}, afull_n, (64 - cnt) > xoff);
    chk(aempty_n == (cnt > xoff), "R8", {ctx, " aempty_n"}, aempty_n, cnt > xoff);
  endtask

  task automatic do_reset(input logic [1:0] fs);
    mon_on = 0;
    a_en = 0; b_en = 0; a_cs_n = 1; b_cs_n = 1;
    rst_n = 0; fsel = fs;
    q.delete(); cnt = 0; xoff = 4 * (int'(fs) + 1);
    repeat (5) @(posedge clk_a);
    repeat (5) @(posedge clk_b);
    @(negedge clk_a);
    chk(full_n == 0, "R5", "full_n in reset", full_n, 0);
    chk(empty_n == 0, "R5", "empty_n in reset", empty_n, 0);
    chk(aempty_n == 0, "R5", "aempty_n in reset", aempty_n, 0);
    chk(afull_n == 1, "R5", "afull_n in reset", afull_n, 1);
    rst_n = 1;
    @(posedge clk_a); @(negedge clk_a);
    chk(full_n == 0, "R6", "full_n after 1st edge", full_n, 0);
    @(posedge clk_a); @(negedge clk_a);
    chk(full_n == 1, "R6", "full_n after 2nd edge", full_n, 1);
    settle();
    check_flags("R7 after reset");
    mon_on = 1;
  endtask

  // blind=1 drives a valid write every cycle regardless of full_n
  task automatic push(input int n, input bit gaps, input bit blind);
    int done = 0;
    while (done < n) begin
      bit will;
      @(negedge clk_a);
      if ((full_n || blind) && !(gaps && ($urandom % 4 == 0))) begin
        a_cs_n = 0; a_wr = 1; a_en = 1; a_mbox = 0;
        a_din = {4'($urandom), 32'($urandom)};
        will = full_n;
        done++;
      end else begin
        a_en = 0; will = 0;
      end
      @(posedge clk_a);
      if (will) begin q.push_back(a_din); cnt++; end
    end
    @(negedge clk_a); a_en = 0;
  endtask

  task automatic pop(input int n, input bit gaps, input bit blind);
    int done = 0;
    bit pend = 0;
    logic [35:0] exp = 0;
    while (done < n) begin
      bit will;
      @(negedge clk_b);
      if (pend) chk(b_dout == exp, "R3", "read data", b_dout, exp);
      pend = 0;
      if ((empty_n || blind) && !(gaps && ($urandom % 4 == 0))) begin
        b_cs_n = 0; b_wr = 0; b_en = 1; b_mbox = 0;
        will = empty_n; done++;
      end else begin
        b_en = 0; will = 0;
      end
      @(posedge clk_b);
      if (will) begin exp = q.pop_front(); cnt--; pend = 1; end
    end
    @(negedge clk_b);
    b_en = 0;
    if (pend) chk(b_dout == exp, "R3", "read data", b_dout, exp);
  endtask

  task automatic bad_write(input int kind);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_a);
      a_din = 36'h5A5A5;
      a_cs_n = 0; a_wr = 1; a_en = 1; a_mbox = 0;
      case (kind)
        0: a_cs_n = 1;
        1: a_wr = 0;
        2: begin a_en = 0; a_cs_n = i[0]; a_wr = i[1]; end
        default: a_mbox = 1;
      endcase
    end
    @(negedge clk_a); a_en = 0; a_mbox = 0;
  endtask

  task automatic bad_read(input int kind);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_b);
      b_cs_n = 0; b_wr = 0; b_en = 1; b_mbox = 0;
      case (kind)
        0: b_cs_n = 1;
        1: b_wr = 1;
        2: begin b_en = 0; b_cs_n = i[0]; b_wr = i[1]; end
        default: b_mbox = 1;
      endcase
    end
    @(negedge clk_b); b_en = 0; b_mbox = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_a);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(2'b00);

    // R4: output enables follow chip select and direction
    for (int c = 0; c < 4; c++) begin
      a_cs_n = c[0]; a_wr = c[1]; b_cs_n = c[0]; b_wr = c[1];
      #1;
      chk(a_oe == (!c[0] && !c[1]), "R4", "a_oe", a_oe, !c[0] && !c[1]);
      chk(b_oe == (!c[0] && !c[1]), "R4", "b_oe", b_oe, !c[0] && !c[1]);
    end
    a_cs_n = 1; b_cs_n = 1;

    // R1: non-matching write decodes store nothing
    for (int k = 0; k < 4; k++) begin
      bad_write(k);
      settle();
      check_flags("R1 bad write");
    end

    // R2: non-matching read decodes remove nothing
    push(1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      bad_read(k);
      settle();
      check_flags("R2 bad read");
    end
    pop(1, 0, 0);
    settle();
    check_flags("R2 drained");

    // R7/R8/R9/R10 threshold sweep for every select value
    for (int f = 0; f < 4; f++) begin
      do_reset(2'(f));
      push(xoff, 0, 0);             settle(); check_flags("R8 count=X");
      push(1, 0, 0);                settle(); check_flags("R8 count=X+1");
      push(63 - xoff - cnt, 0, 0);  settle(); check_flags("R9 free=X+1");
      push(1, 0, 0);                settle(); check_flags("R9 free=X");
      push(64 - cnt, 0, 0);         settle(); check_flags("R10 full");
      push(5, 0, 1);                settle(); check_flags("R10 write when full");
      pop(64, 0, 0);                settle(); check_flags("R10 empty");
      pop(5, 0, 1);                 settle(); check_flags("R10 read when empty");
      push(3, 0, 0); pop(3, 0, 0);  settle(); check_flags("R10 pointers intact");
    end

    // R3: concurrent traffic across unrelated clocks
    do_reset(2'b01);
    fork
      push(300, 1, 0);
      pop(300, 1, 0);
    join
    settle();
    check_flags("R3 after stream");

    finish_run();
  end
endmodule